// File: doc/BRIEF.md
# Peripheral Power State Controller

This block governs the power-management state of an eight-channel serial peripheral that sits on a PCI-style bus. It holds one 16-bit power control/status word that software reads and writes through configuration accesses. Three states are tracked:

- **Uninitialised full power.** Entered at reset.
- **Active full power.** Entered once the driver signals that initialisation is complete.
- **Hot low-power.** Entered when software writes the low-power code.

Memory-space requests and the interrupt request are passed on only in the active full-power state. Configuration accesses are always served.

While the block is in the low-power state, it watches for wake activity on every channel. A wake is either a start bit (a high-to-low transition on a receive line) or a modem-status change flag that turns on. Any wake latches a sticky status flag, and software clears that flag by writing one to it. When the enable bit is also set, the active-low wake output is driven. A write of the full-power code while in low power returns the block straight to the active state and keeps the other register contents. The receive lines are asynchronous and pass through a two-flop synchroniser. The change flags come from logic in the same clock domain.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the state output is 00 (uninitialised), the register reads 0x0000, memAccept and irqOut are 0 and pmeN is 1.
- R2: In state 00, a pulse on drvInitDone moves the state output to 01 (active) on the next clock edge. drvInitDone has no effect in any other state.
- R3: memAccept equals memReq and irqOut equals irqIn only while the state is 01. In every other state both outputs are 0.
- R4: A configuration write with bits [1:0] = 11 enters low power (state 11), and bits [1:0] then read 11. In both full-power states bits [1:0] read 00.
- R5: A write with bits [1:0] = 00 while in state 11 moves the state to 01 (not 00). The enable bit keeps its value unless that same write changes it.
- R6: Writes with bits [1:0] = 01 or 10 leave the state and the readback of bits [1:0] unchanged.
- R7: Register bits [7:2] and [14:9] always read 0.
- R8: In state 11, a falling edge on any rxLine bit sets the status bit (bit 15) on the third clock edge after the line goes low. This happens whatever the enable bit (bit 8) holds.
- R9: In state 11, any bit of msrDelta (four bits per channel, channel n at bits [4n+3:4n]) going from 0 to 1 sets the status bit on the next clock edge.
- R10: Outside state 11, no receive edge or change flag sets the status bit.
- R11: A write with bit 15 = 1 clears the status bit, and a write with bit 15 = 0 leaves it unchanged. If a wake occurs in the same cycle as the clearing write, the status bit is set.
- R12: pmeN is 0 exactly while the status bit, the enable bit and state 11 all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgWrData | input | 16 | Configuration write data |
| cfgRdData | output | 16 | Register readback |
| drvInitDone | input | 1 | Driver initialisation complete pulse |
| memReq | input | 1 | Memory-space request from the bus engine |
| memAccept | output | 1 | Memory request accepted |
| irqIn | input | 1 | Interrupt request from the channels |
| irqOut | output | 1 | Gated interrupt request |
| rxLine | input | 8 | Per-channel asynchronous receive lines |
| msrDelta | input | 32 | Per-channel modem-status change flags, 4 per channel |
| stateOut | output | 2 | Current power state: 00 uninit, 01 active, 11 low power |
| pmeN | output | 1 | Active-low power-management event |

## Verification
Some properties are checked on every cycle:
- The bus and interrupt gating against the state.
- The agreement between the state and the readback of the power field.
- The zero reserved bits.
- The fixed state transitions for the init pulse and for the return from low power.
- The fact that the status bit cannot rise outside low power.
- The condition under which pmeN is driven low.

Some behaviour can only be shown by the bench scenarios:
- The exact three-edge latency through the receive-line synchroniser.
- The way a wake takes precedence over a clearing write in the same cycle.
- The status bit latching while the enable bit is off.
- The sustained agreement with a reference model under random writes, pulses and flag activity.

// File: rtl/pwr_state_pkg.sv
`timescale 1ns/1ps
package pwr_state_pkg;
  localparam int REG_W       = 16;
  localparam int PME_EN_BIT  = 8;
  localparam int PME_STS_BIT = 15;
  localparam logic [1:0] PS_FULL = 2'b00;
  localparam logic [1:0] PS_LOW  = 2'b11;

  typedef enum logic [1:0] {
    ST_D0_UNINIT = 2'b00,
    ST_D0_ACTIVE = 2'b01,
    ST_D3_HOT    = 2'b11
  } pwr_state_e;

  typedef struct packed {
    logic ldPower;    // valid power field write
    logic ldEnable;   // any config write updates enable
    logic clrStatus;  // write-one-to-clear of status
    logic wakeArm;    // wake detection active
  } ctl_strobe_t;
endpackage

// File: rtl/pwr_state_fsm.sv
`timescale 1ns/1ps
module pwr_state_fsm
  import pwr_state_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWr,
  input  logic [1:0]  wrPower,
  input  logic        wrStsClr,
  input  logic        drvInitDone,
  output pwr_state_e  stateQ,
  output ctl_strobe_t strobe
);
  pwr_state_e stateD;
  logic validCode;

  assign validCode = (wrPower == PS_FULL) || (wrPower == PS_LOW);

  always_comb begin
    stateD = stateQ;
    if (cfgWr && wrPower == PS_LOW) begin
      stateD = ST_D3_HOT;
    end else if (cfgWr && wrPower == PS_FULL && stateQ == ST_D3_HOT) begin
      stateD = ST_D0_ACTIVE;
    end else if (stateQ == ST_D0_UNINIT && drvInitDone) begin
      stateD = ST_D0_ACTIVE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_D0_UNINIT;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.ldPower   = cfgWr && validCode;
    strobe.ldEnable  = cfgWr;
    strobe.clrStatus = cfgWr && wrStsClr;
    strobe.wakeArm   = (stateQ == ST_D3_HOT);
  end
endmodule

// File: rtl/pwr_state_dp.sv
`timescale 1ns/1ps
module pwr_state_dp
  import pwr_state_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int DELTA_W = 4,
  localparam int MSR_W  = NUM_CH * DELTA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobe,
  input  logic [1:0]        wrPower,
  input  logic              wrEnable,
  input  logic [NUM_CH-1:0] rxLine,
  input  logic [MSR_W-1:0]  msrDelta,
  output logic [REG_W-1:0]  cfgRdData,
  output logic              pmeStatus,
  output logic              pmeEnable
);
  logic [1:0]        powerField;
  logic [NUM_CH-1:0] rxMeta, rxSync, rxLast, rxFall, chWake;
  logic [MSR_W-1:0]  msrLast, msrRise;
  logic              wakeHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta  <= '1;
      rxSync  <= '1;
      rxLast  <= '1;
      msrLast <= '0;
    end else begin
      rxMeta  <= rxLine;
      rxSync  <= rxMeta;
      rxLast  <= rxSync;
      msrLast <= msrDelta;
    end
  end

  assign rxFall  = rxLast & ~rxSync;
  assign msrRise = msrDelta & ~msrLast;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign chWake[ch] = rxFall[ch] | (|msrRise[ch*DELTA_W +: DELTA_W]);
  end

  assign wakeHit = strobe.wakeArm && (|chWake);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerField <= PS_FULL;
      pmeEnable  <= 1'b0;
      pmeStatus  <= 1'b0;
    end else begin
      if (strobe.ldPower)  powerField <= wrPower;
      if (strobe.ldEnable) pmeEnable  <= wrEnable;
      if (wakeHit)                pmeStatus <= 1'b1;
      else if (strobe.clrStatus)  pmeStatus <= 1'b0;
    end
  end

  always_comb begin
    cfgRdData              = '0;
    cfgRdData[1:0]         = powerField;
    cfgRdData[PME_EN_BIT]  = pmeEnable;
    cfgRdData[PME_STS_BIT] = pmeStatus;
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
`timescale 1ns/1ps
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int DELTA_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWr,
  input  logic [15:0]               cfgWrData,
  output logic [15:0]               cfgRdData,
  input  logic                      drvInitDone,
  input  logic                      memReq,
  output logic                      memAccept,
  input  logic                      irqIn,
  output logic                      irqOut,
  input  logic [NUM_CH-1:0]         rxLine,
  input  logic [NUM_CH*DELTA_W-1:0] msrDelta,
  output logic [1:0]                stateOut,
  output logic                      pmeN
);
  pwr_state_e  stateQ;
  ctl_strobe_t strobe;
  logic        pmeStatus, pmeEnable, isActive, isLow;
  logic        unusedWrBits;

  assign unusedWrBits = ^{cfgWrData[14:9], cfgWrData[7:2]};

  pwr_state_fsm i_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWr       (cfgWr),
    .wrPower     (cfgWrData[1:0]),
    .wrStsClr    (cfgWrData[PME_STS_BIT]),
    .drvInitDone (drvInitDone),
    .stateQ      (stateQ),
    .strobe      (strobe)
  );

  pwr_state_dp #(.NUM_CH(NUM_CH), .DELTA_W(DELTA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrPower   (cfgWrData[1:0]),
    .wrEnable  (cfgWrData[PME_EN_BIT]),
    .rxLine    (rxLine),
    .msrDelta  (msrDelta),
    .cfgRdData (cfgRdData),
    .pmeStatus (pmeStatus),
    .pmeEnable (pmeEnable)
  );

  assign isActive  = (stateQ == ST_D0_ACTIVE);
  assign isLow     = (stateQ == ST_D3_HOT);
  assign memAccept = memReq & isActive;
  assign irqOut    = irqIn & isActive;
  assign pmeN      = ~(pmeStatus & pmeEnable & isLow);
  assign stateOut  = stateQ;
endmodule

// File: rtl/pwr_state_chk.sv
`timescale 1ns/1ps
module pwr_state_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWr,
  input logic [15:0] cfgWrData,
  input logic [15:0] cfgRdData,
  input logic        drvInitDone,
  input logic        memReq,
  input logic        memAccept,
  input logic        irqOut,
  input logic [1:0]  stateOut,
  input logic        pmeN
);
  // R2
  init_to_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'b00 && drvInitDone && !(cfgWr && cfgWrData[1:0] == 2'b11))
      |=> stateOut == 2'b01);
  // R3
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    memAccept |-> (memReq && stateOut == 2'b01));
  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> stateOut == 2'b01);
  // R4
  field_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'b11) == (cfgRdData[1:0] == 2'b11));
  // R5
  wake_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'b11 && cfgWr && cfgWrData[1:0] == 2'b00) |=> stateOut == 2'b01);
  // R6
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && (cfgWrData[1:0] == 2'b01 || cfgWrData[1:0] == 2'b10))
      |=> $stable(cfgRdData[1:0]));
  // R7
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[7:2] == 6'd0 && cfgRdData[14:9] == 6'd0);
  // R10
  no_wake_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut != 2'b11 && !cfgRdData[15]) |=> !cfgRdData[15]);
  // R11
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgWrData[15] && stateOut != 2'b11) |=> !cfgRdData[15]);
  // R12
  pme_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pmeN |-> (cfgRdData[15] && cfgRdData[8] && stateOut == 2'b11));
endmodule

bind pwr_state_ctrl pwr_state_chk i_chk (.*);

// File: tb/test_pwr_state_ctrl.sv
`timescale 1ns/1ps
module test_pwr_state_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cfgRdData;
  logic        drvInitDone = 1'b0;
  logic        memReq = 1'b0;
  logic        memAccept;
  logic        irqIn = 1'b0;
  logic        irqOut;
  logic [7:0]  rxLine = '1;
  logic [31:0] msrDelta = '0;
  logic [1:0]  stateOut;
  logic        pmeN;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model
  logic [1:0]  mSt = 2'b00;
  logic        mEn = 1'b0, mSts = 1'b0;
  logic [31:0] mMsrPrev = '0;
  logic [7:0]  m1 = '1, m2 = '1, m3 = '1;

  always #10 clk = ~clk;

  pwr_state_ctrl i_pwr_state_ctrl (.*);

  function automatic logic [15:0] expRd();
    return {mSts, 6'd0, mEn, 6'd0, (mSt == 2'b11) ? 2'b11 : 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    #1;
    check({req, " rd"}, cfgRdData, expRd());
    check({req, " state"}, stateOut, mSt);
    check({req, " mem"}, memAccept, memReq && mSt == 2'b01);
    check({req, " irq"}, irqOut, irqIn && mSt == 2'b01);
    check({req, " pme"}, pmeN, !(mSts && mEn && mSt == 2'b11));
  endtask

  task automatic step();
    logic wake;
    logic [1:0] nSt;
    wake = (mSt == 2'b11) && ((|(m3 & ~m2)) || (|(msrDelta & ~mMsrPrev)));
    nSt = mSt;
    if (cfgWr && cfgWrData[1:0] == 2'b11) nSt = 2'b11;
    else if (cfgWr && cfgWrData[1:0] == 2'b00 && mSt == 2'b11) nSt = 2'b01;
    else if (mSt == 2'b00 && drvInitDone) nSt = 2'b01;
    @(posedge clk);
    if (wake) mSts = 1'b1;
    else if (cfgWr && cfgWrData[15]) mSts = 1'b0;
    if (cfgWr) mEn = cfgWrData[8];
    mSt = nSt;
    mMsrPrev = msrDelta;
    m3 = m2; m2 = m1; m1 = rxLine;
    @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [15:0] d);
    cfgWr = 1'b1; cfgWrData = d;
    step();
    cfgWr = 1'b0; cfgWrData = '0;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    memReq = 1'b1; irqIn = 1'b1;
    // R1 reset state
    #1;
    check("R1 rd", cfgRdData, 16'h0000);
    check("R1 state", stateOut, 2'b00);
    check("R1 mem", memAccept, 1'b0);
    check("R1 irq", irqOut, 1'b0);
    check("R1 pme", pmeN, 1'b1);
    // R3 gating in uninit, R10 no wake outside low power
    msrDelta = 32'h0000_00f0;
    step();
    msrDelta = '0;
    checkAll("R3/R10 uninit");
    check("R10 sts", cfgRdData[15], 1'b0);
    // R2 init pulse
    drvInitDone = 1'b1; step(); drvInitDone = 1'b0;
    checkAll("R2");
    check("R2 state", stateOut, 2'b01);
    check("R3 mem active", memAccept, 1'b1);
    check("R3 irq active", irqOut, 1'b1);
    // R10 receive edge in active state
    rxLine[2] = 1'b0; repeat (4) step(); rxLine[2] = 1'b1; repeat (4) step();
    check("R10 rx active", cfgRdData[15], 1'b0);
    // R6 reserved codes
    cfgWrite(16'h0001); checkAll("R6 01");
    check("R6 state", stateOut, 2'b01);
    cfgWrite(16'h0002); checkAll("R6 10");
    // R4 enter low power with enable
    cfgWrite(16'h0103); checkAll("R4");
    check("R4 field", cfgRdData[1:0], 2'b11);
    check("R4 mem blocked", memAccept, 1'b0);
    check("R4 irq blocked", irqOut, 1'b0);
    // R6 reserved code in low power
    cfgWrite(16'h0102);
    check("R6 low", stateOut, 2'b11);
    // R2 init pulse ignored in low power
    drvInitDone = 1'b1; step(); drvInitDone = 1'b0;
    check("R2 ignored", stateOut, 2'b11);
    // R8 receive edge latency
    rxLine[5] = 1'b0;
    step(); step();
    #1 check("R8 not yet", cfgRdData[15], 1'b0);
    step();
    #1 check("R8 set", cfgRdData[15], 1'b1);
    check("R12 low", pmeN, 1'b0);
    rxLine[5] = 1'b1; repeat (3) step();
    // R11 clear
    cfgWrite(16'h0103); check("R11 keep", cfgRdData[15], 1'b1);
    cfgWrite(16'h8103); #1 check("R11 clr", cfgRdData[15], 1'b0);
    check("R12 high", pmeN, 1'b1);
    // R9 change flag on channel 7, enable off: status sets, pme stays high
    cfgWrite(16'h0003);
    msrDelta = 32'h4000_0000; step();
    #1 check("R9 set", cfgRdData[15], 1'b1);
    check("R12 disabled", pmeN, 1'b1);
    // R11 wake wins over clear in the same cycle
    msrDelta = 32'h4000_0001;
    cfgWrite(16'h8103);
    #1 check("R11 wake wins", cfgRdData[15], 1'b1);
    check("R12 enabled", pmeN, 1'b0);
    msrDelta = '0; step();
    // R5 return keeps enable and status
    cfgWrite(16'h0100); checkAll("R5");
    check("R5 state", stateOut, 2'b01);
    check("R5 en", cfgRdData[8], 1'b1);
    check("R12 not low", pmeN, 1'b1);
    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      cfgWr = ($urandom % 5) == 0;
      cfgWrData = d;
      drvInitDone = ($urandom % 7) == 0;
      memReq = 1'($urandom);
      irqIn = 1'($urandom);
      if ($urandom % 6 == 0) rxLine = rxLine ^ (8'd1 << ($urandom % 8));
      if ($urandom % 5 == 0) msrDelta = $urandom & $urandom;
      if ($urandom % 40 == 0) begin
        rstN = 1'b0; step(); rstN = 1'b1;
        mSt = 2'b00; mEn = 1'b0; mSts = 1'b0; mMsrPrev = '0; m1 = '1; m2 = '1; m3 = '1;
        continue;
      end
      checkAll("R3/R8/R9/R11/R12 random");
      step();
    end
    cfgWr = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule